// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

The block adds numbers one bit pair per clock. Two W-bit registers shift right together. One is the accumulator and the other is the addend. A single full adder combines their low bits with a stored carry. Each sum bit is fed back into the top of the accumulator, so after W shifts the accumulator holds the old total plus the addend, modulo 2^W.

During the same W shifts, the addend register takes in the next operand on a serial input, least significant bit first. A caller therefore streams operand k while operand k-1 is being added, and keeps a running total without any parallel path.

A start pulse begins an addition, and the carry is cleared at that moment. A down-counter keeps shifting enabled for exactly W clocks and then produces a one-clock done pulse. A clear request, honoured only while idle, empties the accumulator and the carry.

Top module: `bitserial_accum`

## Requirements
- R1: While rst is high at a clock edge, acc, the carry and the stored addend become 0, and busy and done become 0.
- R2: A start seen at an edge while idle, with clr_acc low, makes busy high for exactly W cycles. At the edge that ends the W-th busy cycle, busy falls and done rises for exactly one cycle.
- R3: On every busy edge the accumulator shifts right by one position and the new sum bit enters bit W-1.
- R4: Each sum bit is x XOR y XOR c, where x = acc[0], y = the addend's bit 0 and c is the carry. The next carry is set when x and y are both 1, cleared when both are 0, and held otherwise. Bits are processed from least significant to most significant.
- R5: The carry is cleared on every accepted start. After an addition completes, acc equals the previous acc plus the stored addend, modulo 2^W, with no carry left over from an earlier addition.
- R6: ser_in is sampled on each busy edge, least significant bit on the first busy edge. The W bits taken in during one addition become the addend of the next addition.
- R7: clr_acc seen while idle sets acc and the carry to 0 at that edge. If start is high at the same edge, the start is ignored and busy stays low.
- R8: A start seen while busy is ignored: the busy length and the result are unchanged.
- R9: clr_acc seen while busy is ignored, and the addition completes with the normal result.
- R10: Successive additions without a clear accumulate a running total modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an addition when idle |
| clr_acc | input | 1 | Zero the accumulator and carry when idle |
| ser_in | input | 1 | Serial bit of the next operand, LSB first |
| acc | output | W | Accumulator contents |
| busy | output | 1 | High while shifting |
| done | output | 1 | One-cycle pulse after the last shift |

## Verification
The total is a running one, so a bad carry or a mis-ordered bit shows up in acc at the very next done pulse. Because later additions build on that value, the error then carries forward into every following result. A counter that is off by one either moves the done pulse or leaves the accumulator rotated by one position, and either fault is visible when that addition finishes. The bench runs every pair of 4-bit operands and then chains additions, including starts and clears issued mid-stream, so any of these faults shows up within a few clocks of the first affected done.

// File: rtl/bitserial_accum.sv
module bitserial_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         clr_acc,
  input  logic         ser_in,
  output logic [W-1:0] acc,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  addend;
  logic [CW-1:0] cnt;
  logic          carry;
  logic          x, y, sum, j_in, k_in, carry_nx;

  assign x        = acc[0];
  assign y        = addend[0];
  assign sum      = x ^ y ^ carry;
  assign j_in     = x & y;
  assign k_in     = ~x & ~y;
  assign carry_nx = j_in | (carry & ~k_in);
  assign busy     = cnt != '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      addend <= '0;
      carry  <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc    <= {sum, acc[W-1:1]};
        addend <= {ser_in, addend[W-1:1]};
        carry  <= carry_nx;
        cnt    <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end else if (clr_acc) begin
        acc   <= '0;
        carry <= 1'b0;
      end else if (start) begin
        cnt   <= CW'(W);
        carry <= 1'b0;
      end
    end
  end

  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !clr_acc) |=> (busy && cnt == CW'(W) && carry == 1'b0));
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  a_r3_shift_right: assert property (@(posedge clk) disable iff (rst)
    busy |=> (acc[W-2:0] == $past(acc[W-1:1])));
  a_r7_clear_idle: assert property (@(posedge clk) disable iff (rst)
    (clr_acc && !busy) |=> (acc == '0 && !busy));
  a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: tb/bitserial_accum_test.sv
`timescale 1ns/1ps
module bitserial_accum_test;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst, start, clr_acc, ser_in;
  logic [W-1:0] acc;
  logic busy, done;

  int total = 0;
  int fails = 0;
  int acc_m = 0;
  int add_m = 0;

  always #4 clk = ~clk;

  bitserial_accum #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .clr_acc(clr_acc),
    .ser_in(ser_in), .acc(acc), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clr_acc = 1'b1;
    @(negedge clk);
    clr_acc = 1'b0;
    acc_m = 0;
    chk(acc == 0, "R7 clear", acc, 0);
  endtask

  task automatic run_add(input int nxt, input bit poke_start, input bit poke_clr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < W; i++) begin
      chk(busy == 1'b1, "R2 busy during shift", busy, 1);
      ser_in  = nxt[i];
      start   = poke_start && (i == 1);
      clr_acc = poke_clr && (i == 2);
      @(negedge clk);
    end
    start = 1'b0;
    clr_acc = 1'b0;
    ser_in = 1'b0;
    acc_m = (acc_m + add_m) % M;
    add_m = nxt;
    chk(done == 1'b1, "R2 done raised", done, 1);
    chk(busy == 1'b0, "R2 busy dropped", busy, 0);
    chk(acc == acc_m, poke_start ? "R8 result" : (poke_clr ? "R9 result" : "R5 sum"), acc, acc_m);
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", done, 0);
    chk(busy == 1'b0, "R8 no restart", busy, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; clr_acc = 1'b0; ser_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(acc == 0, "R1 acc reset", acc, 0);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);

    // R4 R6: exhaustive operand pairs
    for (int a = 0; a < M; a++) begin
      for (int b = 0; b < M; b++) begin
        do_clear();
        run_add(a, 1'b0, 1'b0);
        run_add(b, 1'b0, 1'b0);
        run_add((a * 3 + b) % M, 1'b0, 1'b0);
      end
    end

    // R10: chained running total, with R8 and R9 pokes
    do_clear();
    for (int k = 0; k < 40; k++)
      run_add((k * 7 + 5) % M, k % 5 == 1, k % 5 == 3);

    // R7: clear and start together; start ignored
    clr_acc = 1'b1; start = 1'b1;
    @(negedge clk);
    clr_acc = 1'b0; start = 1'b0;
    acc_m = 0;
    chk(busy == 1'b0, "R7 start ignored", busy, 0);
    chk(acc == 0, "R7 acc zero", acc, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R7 still idle", busy, 0);
    run_add(9, 1'b0, 1'b0);
    run_add(0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule